// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of 32 general-purpose pins on a simple memory-mapped register bus. Software drives each pin's output level and output enable through separate set and clear addresses. Writing a 1 bit changes that pin, and writing a 0 bit leaves it alone. No read-modify-write is needed. The bank also presents per-pin pull configuration to the pad ring as two one-hot-per-pin vectors, one for pull-up and one for pull-down.

Incoming pin levels pass through a two-flop synchronizer. An optional per-pin debounce filter follows, and it is paced by a single divider that all pins share. The bank watches the filtered level for rising and falling transitions. Each direction has its own enable register and its own sticky pending register. Software clears a pending bit by writing a 1 to it. The single interrupt line is active while any pending bit of either direction is set.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every output value, output-enable, edge-enable, pending, debounce-enable, divider, pull-enable and pull-sense bit is 0. The interrupt line is 0.
- R2: A write to address 0x04 sets the output bits where the write data is 1, and a write to 0x08 clears them. A 0 data bit leaves its pin unchanged. Reads at either address return the output register.
- R3: A write to 0x0C sets output-enable bits and a write to 0x10 clears them, with the same one-bit-only rule. Reads at either address return the enable register, which drives `pin_oe`.
- R4: A read at 0x00 returns the synchronized pin levels. A change on `pin_in` appears there two clock edges after it is applied, and not after one.
- R5: When bit n of the rising-enable register (0x14) is set, a low-to-high transition on pin n sets bit n of the rising-pending register (0x1C). With the enable bit clear, the transition sets nothing.
- R6: When bit n of the falling-enable register (0x18) is set, a high-to-low transition on pin n sets bit n of the falling-pending register (0x20).
- R7: A pending bit stays set until software writes a 1 to that bit of its pending address. Writing 0 bits, or 1 bits for other pins, leaves it set.
- R8: `irq` is 1 exactly when at least one bit of either pending register is set.
- R9: If a new enabled edge on a pin is detected in the same cycle as a write-one clear of that pin's pending bit, the bit stays set.
- R10: When debounce is enabled for a pin (register 0x24), a level must hold unchanged for a full divider period before it can cause an edge, so a short glitch produces no pending bit. With debounce off, the same glitch does produce one.
- R11: The shared divider lives in bits 29:16 of register 0x28. A tick occurs every divider+1 cycles. The other bits of that register read as 0.
- R12: `pull_up` is pull-enable (0x2C) AND pull-sense (0x30), and `pull_dn` is pull-enable AND NOT pull-sense. Sense 1 therefore selects pull-up and sense 0 selects pull-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte address for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin |
| pull_up | output | 32 | Pull-up request per pin |
| pull_dn | output | 32 | Pull-down request per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The properties assume that `wr_en` and `addr` are known whenever reset is low, and that a clear of a pending register is the only way software touches pending state. The stimulus keeps to this. It changes `pin_in` and bus signals only on falling clock edges and holds each write for exactly one rising edge. The same-cycle clear case is built by counting the two synchronizer flops, so that the clear strobe lands on the edge where the transition is detected.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DIV_LSB = 16;

    localparam logic [ADDR_W-1:0] RA_IN        = 8'h00;
    localparam logic [ADDR_W-1:0] RA_OUT_SET   = 8'h04;
    localparam logic [ADDR_W-1:0] RA_OUT_CLR   = 8'h08;
    localparam logic [ADDR_W-1:0] RA_OE_SET    = 8'h0C;
    localparam logic [ADDR_W-1:0] RA_OE_CLR    = 8'h10;
    localparam logic [ADDR_W-1:0] RA_RISE_EN   = 8'h14;
    localparam logic [ADDR_W-1:0] RA_FALL_EN   = 8'h18;
    localparam logic [ADDR_W-1:0] RA_RISE_PEND = 8'h1C;
    localparam logic [ADDR_W-1:0] RA_FALL_PEND = 8'h20;
    localparam logic [ADDR_W-1:0] RA_DEB_EN    = 8'h24;
    localparam logic [ADDR_W-1:0] RA_DIV       = 8'h28;
    localparam logic [ADDR_W-1:0] RA_PULL_EN   = 8'h2C;
    localparam logic [ADDR_W-1:0] RA_PULL_SNS  = 8'h30;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } bus_req_t;

    // Mask of 1 bits written to a given address, else all zero
    function automatic logic [BUS_W-1:0] hit_mask(bus_req_t req, logic [ADDR_W-1:0] a);
        return (req.wr && req.addr == a) ? req.data : '0;
    endfunction

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DIVW  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] deb_en,
    input  logic [DIVW-1:0]  div,
    output logic [NPINS-1:0] sync_lvl,
    output logic [NPINS-1:0] eff_lvl
);

    logic [NPINS-1:0] meta_q, sync_q, sync_d1;
    logic [DIVW-1:0]  cnt_q;
    logic             tick;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            sync_q  <= '0;
            sync_d1 <= '0;
            cnt_q   <= '0;
        end else begin
            meta_q  <= pin_in;
            sync_q  <= meta_q;
            sync_d1 <= sync_q;
            cnt_q   <= tick ? '0 : cnt_q + DIVW'(1);
        end
    end

    assign sync_lvl = sync_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic filt_q, quiet_q, moved, take;

        assign moved = sync_q[p] ^ sync_d1[p];
        assign take  = !deb_en[p] || (tick && quiet_q && !moved);

        always_ff @(posedge clk) begin
            if (rst) begin
                filt_q  <= 1'b0;
                quiet_q <= 1'b0;
            end else begin
                quiet_q <= tick ? !moved : (quiet_q && !moved);
                if (take) filt_q <= sync_q[p];
            end
        end

        assign eff_lvl[p] = deb_en[p] ? filt_q : sync_q[p];
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] rise_clr,
    input  logic [NPINS-1:0] fall_clr,
    output logic [NPINS-1:0] rise_pend,
    output logic [NPINS-1:0] fall_pend,
    output logic             irq
);

    logic [NPINS-1:0] lvl_q, rise_hit, fall_hit;

    assign rise_hit = lvl & ~lvl_q & rise_en;
    assign fall_hit = ~lvl & lvl_q & fall_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= '0;
            rise_pend <= '0;
            fall_pend <= '0;
        end else begin
            lvl_q     <= lvl;
            // a fresh edge outranks the clear in the same cycle
            rise_pend <= (rise_pend & ~rise_clr) | rise_hit;
            fall_pend <= (fall_pend & ~fall_clr) | fall_hit;
        end
    end

    assign irq = |{rise_pend, fall_pend};

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DIVW  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [BUS_W-1:0] rdata,
    input  logic [NPINS-1:0] sync_lvl,
    input  logic [NPINS-1:0] rise_pend,
    input  logic [NPINS-1:0] fall_pend,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] oe_q,
    output logic [NPINS-1:0] rise_en,
    output logic [NPINS-1:0] fall_en,
    output logic [NPINS-1:0] deb_en,
    output logic [DIVW-1:0]  div_q,
    output logic [NPINS-1:0] pull_en,
    output logic [NPINS-1:0] pull_sns,
    output logic [NPINS-1:0] rise_clr,
    output logic [NPINS-1:0] fall_clr
);

    logic [NPINS-1:0] wd;
    assign wd = req.data[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= '0;
            oe_q     <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            deb_en   <= '0;
            div_q    <= '0;
            pull_en  <= '0;
            pull_sns <= '0;
        end else if (req.wr) begin
            case (req.addr)
                RA_OUT_SET:  out_q    <= out_q | wd;
                RA_OUT_CLR:  out_q    <= out_q & ~wd;
                RA_OE_SET:   oe_q     <= oe_q | wd;
                RA_OE_CLR:   oe_q     <= oe_q & ~wd;
                RA_RISE_EN:  rise_en  <= wd;
                RA_FALL_EN:  fall_en  <= wd;
                RA_DEB_EN:   deb_en   <= wd;
                RA_DIV:      div_q    <= req.data[DIV_LSB +: DIVW];
                RA_PULL_EN:  pull_en  <= wd;
                RA_PULL_SNS: pull_sns <= wd;
                default: ;
            endcase
        end
    end

    logic [BUS_W-1:0] rclr_full, fclr_full;
    assign rclr_full = hit_mask(req, RA_RISE_PEND);
    assign fclr_full = hit_mask(req, RA_FALL_PEND);
    assign rise_clr  = rclr_full[NPINS-1:0];
    assign fall_clr  = fclr_full[NPINS-1:0];

    always_comb begin
        rdata = '0;
        case (req.addr)
            RA_IN:                   rdata[NPINS-1:0] = sync_lvl;
            RA_OUT_SET, RA_OUT_CLR:  rdata[NPINS-1:0] = out_q;
            RA_OE_SET, RA_OE_CLR:    rdata[NPINS-1:0] = oe_q;
            RA_RISE_EN:              rdata[NPINS-1:0] = rise_en;
            RA_FALL_EN:              rdata[NPINS-1:0] = fall_en;
            RA_RISE_PEND:            rdata[NPINS-1:0] = rise_pend;
            RA_FALL_PEND:            rdata[NPINS-1:0] = fall_pend;
            RA_DEB_EN:               rdata[NPINS-1:0] = deb_en;
            RA_DIV:                  rdata[DIV_LSB +: DIVW] = div_q;
            RA_PULL_EN:              rdata[NPINS-1:0] = pull_en;
            RA_PULL_SNS:             rdata[NPINS-1:0] = pull_sns;
            default:                 rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DIVW  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pull_up,
    output logic [NPINS-1:0]  pull_dn,
    output logic              irq
);

    bus_req_t req;
    assign req = '{wr: wr_en, addr: addr, data: wdata};

    logic [NPINS-1:0] sync_lvl, eff_lvl;
    logic [NPINS-1:0] rise_en, fall_en, deb_en, pull_en, pull_sns;
    logic [NPINS-1:0] rise_clr, fall_clr, rise_pend, fall_pend;
    logic [DIVW-1:0]  div_q;

    gpio_regs #(.NPINS(NPINS), .DIVW(DIVW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .rdata     (rdata),
        .sync_lvl  (sync_lvl),
        .rise_pend (rise_pend),
        .fall_pend (fall_pend),
        .out_q     (pin_out),
        .oe_q      (pin_oe),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .deb_en    (deb_en),
        .div_q     (div_q),
        .pull_en   (pull_en),
        .pull_sns  (pull_sns),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr)
    );

    gpio_in_filter #(.NPINS(NPINS), .DIVW(DIVW)) filt_i (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .deb_en   (deb_en),
        .div      (div_q),
        .sync_lvl (sync_lvl),
        .eff_lvl  (eff_lvl)
    );

    gpio_edge_irq #(.NPINS(NPINS)) edge_i (
        .clk       (clk),
        .rst       (rst),
        .lvl       (eff_lvl),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .rise_pend (rise_pend),
        .fall_pend (fall_pend),
        .irq       (irq)
    );

    assign pull_up = pull_en & pull_sns;
    assign pull_dn = pull_en & ~pull_sns;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pull_up,
    input logic [NPINS-1:0]  pull_dn,
    input logic              irq
);

    logic pend_wr;
    assign pend_wr = wr_en && (addr == RA_RISE_PEND || addr == RA_FALL_PEND);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq)); // R1

    AST_OUT_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_OUT_SET) |=>
        ((pin_out & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0]))); // R2

    AST_OUT_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_OUT_CLR) |=>
        ((pin_out & $past(wdata[NPINS-1:0])) == '0)); // R2

    AST_OE_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_OE_SET) |=>
        ((pin_oe & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0]))); // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !pend_wr) |=> irq); // R7

    AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(pend_wr)); // R7

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (pull_up & pull_dn) == '0); // R12

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pull_up (pull_up),
    .pull_dn (pull_dn),
    .irq     (irq)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;
    import gpio_bank_pkg::*;

    localparam int NP = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BUS_W-1:0]  wdata = '0;
    logic [BUS_W-1:0]  rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out, pin_oe, pull_up, pull_dn;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_bank #(.NPINS(NP), .DIVW(14)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (exp[i]) exp[i] = 1'b0;
        rd(RA_OUT_SET, d);   chk("R1 out", d, 0);
        rd(RA_OE_SET, d);    chk("R1 oe", d, 0);
        rd(RA_RISE_EN, d);   chk("R1 rise_en", d, 0);
        rd(RA_FALL_EN, d);   chk("R1 fall_en", d, 0);
        rd(RA_RISE_PEND, d); chk("R1 rise_pend", d, 0);
        rd(RA_FALL_PEND, d); chk("R1 fall_pend", d, 0);
        rd(RA_DEB_EN, d);    chk("R1 deb_en", d, 0);
        rd(RA_DIV, d);       chk("R1 div", d, 0);
        rd(RA_PULL_EN, d);   chk("R1 pull_en", d, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 output set/clear sweep
        exp = 0;
        for (int p = 0; p < NP; p++) begin
            wr(RA_OUT_SET, 32'd1 << p);
            exp |= 32'd1 << p;
            chk("R2 set", pin_out, exp);
        end
        for (int p = 0; p < NP; p += 2) begin
            wr(RA_OUT_CLR, 32'd1 << p);
            exp &= ~(32'd1 << p);
            chk("R2 clr", pin_out, exp);
        end
        wr(RA_OUT_SET, 0); chk("R2 zero set", pin_out, exp);
        wr(RA_OUT_CLR, 0); chk("R2 zero clr", pin_out, exp);
        rd(RA_OUT_CLR, d); chk("R2 readback", d, exp);

        // R3 output enable
        wr(RA_OE_SET, 32'hA5A5_0F0F); chk("R3 set", pin_oe, 32'hA5A5_0F0F);
        wr(RA_OE_CLR, 32'h0000_FFFF); chk("R3 clr", pin_oe, 32'hA5A5_0000);
        wr(RA_OE_CLR, 0);             chk("R3 zero", pin_oe, 32'hA5A5_0000);
        rd(RA_OE_SET, d);             chk("R3 readback", d, 32'hA5A5_0000);

        // R4 two-flop input latency
        @(negedge clk); pin_in = 32'h0000_0020;
        rd(RA_IN, d); chk("R4 after one edge", d, 0);
        rd(RA_IN, d); chk("R4 after two edges", d, 32'h0000_0020);
        pin_in = 0; idle(4);

        // R5 rising edges, every pin
        wr(RA_RISE_EN, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            @(negedge clk); pin_in = 32'd1 << p;
            idle(4);
            rd(RA_RISE_PEND, d); chk("R5 pend", d, 32'd1 << p);
            chk("R8 irq on", {31'd0, irq}, 1);
            rd(RA_FALL_PEND, d); chk("R6 no fall when disabled", d, 0);
            wr(RA_RISE_PEND, 32'd1 << p);
            chk("R8 irq off", {31'd0, irq}, 0);
        end
        @(negedge clk); pin_in = 0; idle(4);
        wr(RA_RISE_EN, 0);
        @(negedge clk); pin_in = 32'h80; idle(4);
        rd(RA_RISE_PEND, d); chk("R5 disabled", d, 0);
        @(negedge clk); pin_in = 32'hFFFF_FFFF; idle(4);

        // R6 falling edges, every pin
        wr(RA_FALL_EN, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            @(negedge clk); pin_in = ~(32'd1 << p);
            idle(4);
            rd(RA_FALL_PEND, d); chk("R6 pend", d, 32'd1 << p);
            wr(RA_FALL_PEND, 32'd1 << p);
        end
        @(negedge clk); pin_in = 32'hFFFF_FFFF; idle(4);
        wr(RA_FALL_PEND, 32'hFFFF_FFFF);

        // R7 sticky pending, R8 combine
        wr(RA_FALL_EN, 32'h8);
        wr(RA_RISE_EN, 32'h200);
        @(negedge clk); pin_in = 32'hFFFF_FDF7; idle(4);
        @(negedge clk); pin_in = 32'hFFFF_FFF7; idle(4);
        wr(RA_FALL_PEND, 0);       rd(RA_FALL_PEND, d); chk("R7 zero write", d, 32'h8);
        wr(RA_FALL_PEND, 32'h10);  rd(RA_FALL_PEND, d); chk("R7 other pin", d, 32'h8);
        rd(RA_RISE_PEND, d);       chk("R8 both rise", d, 32'h200);
        wr(RA_RISE_PEND, 32'h200); chk("R8 fall keeps irq", {31'd0, irq}, 1);
        wr(RA_FALL_PEND, 32'h8);   rd(RA_FALL_PEND, d); chk("R7 cleared", d, 0);
        chk("R8 irq low", {31'd0, irq}, 0);

        // R9 edge and clear in the same cycle
        wr(RA_FALL_EN, 0);
        @(negedge clk); pin_in = 0; idle(4);
        wr(RA_RISE_EN, 32'h1);
        wr(RA_RISE_PEND, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'h1; idle(4);
        @(negedge clk); pin_in = 32'h0; idle(4);
        rd(RA_RISE_PEND, d); chk("R9 pre", d, 32'h1);
        @(negedge clk); pin_in = 32'h1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = RA_RISE_PEND; wdata = 32'h1;
        @(negedge clk); wr_en = 1'b0; wdata = 0;
        rd(RA_RISE_PEND, d); chk("R9 edge wins", d, 32'h1);
        @(negedge clk); pin_in = 0; idle(4);
        wr(RA_RISE_PEND, 32'hFFFF_FFFF);

        // R11 divider field
        wr(RA_DIV, 32'hFFFF_FFFF); rd(RA_DIV, d); chk("R11 field", d, 32'h3FFF_0000);

        // R10 debounce
        wr(RA_DIV, 32'd20 << 16);
        wr(RA_RISE_EN, 32'h4);
        wr(RA_DEB_EN, 32'h4);
        idle(50);
        @(negedge clk); pin_in = 32'h4; idle(3);
        @(negedge clk); pin_in = 0; idle(80);
        rd(RA_RISE_PEND, d); chk("R10 glitch filtered", d, 0);
        @(negedge clk); pin_in = 32'h4; idle(100);
        rd(RA_RISE_PEND, d); chk("R10 long level", d, 32'h4);
        @(negedge clk); pin_in = 0; idle(100);
        wr(RA_DEB_EN, 0);
        wr(RA_RISE_PEND, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'h4; idle(3);
        @(negedge clk); pin_in = 0; idle(6);
        rd(RA_RISE_PEND, d); chk("R10 glitch passes without debounce", d, 32'h4);

        // R12 pulls
        wr(RA_PULL_EN, 32'h0000_00FF);
        wr(RA_PULL_SNS, 32'h0000_000F);
        chk("R12 up", pull_up, 32'h0000_000F);
        chk("R12 dn", pull_dn, 32'h0000_00F0);
        wr(RA_PULL_EN, 0);
        chk("R12 off", pull_up | pull_dn, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule